// File: doc/BRIEF.md
# Instruction Timing and Decode Generator

This block produces the step timing and the opcode decode for a small 16-bit accumulator machine. A 4-bit step counter is turned into sixteen one-hot timing lines, so that exactly one step line is high in every cycle. The counter advances while the machine runs, stays put while it is halted, and returns to the first step whenever the execute logic asks for it. It also returns to the first step on its own right after an instruction of the register class or the input/output class has been recognised.

An instruction word is captured by a load strobe. Its three opcode bits drive eight one-hot decode lines, its top bit is presented as the indirect flag, and its twelve low bits are passed on unchanged as qualifier bits for the execute logic. Two class flags are raised in the fourth step when the opcode is all ones: one for register-class instructions (indirect flag low) and one for input/output instructions (indirect flag high). Instruction execution, the bus and memory lie outside the block.

Top module: `tdg_top`

## Requirements
- R1: A synchronous reset sets the step counter to 0 and clears the captured word, so after reset tOneHot[0], dOneHot[0] are high, indirect is 0 and qualBits is 0.
- R2: With run high and no clear request, the step counter advances by one per clock and wraps from 15 to 0.
- R3: With run low and no clear request, the step counter keeps its value and tOneHot does not change.
- R4: scClear high returns the step counter to 0 at the next edge, whatever the value of run.
- R5: tOneHot[k] is high exactly when the step counter equals k; exactly one bit of tOneHot is high in every cycle.
- R6: When irLoad is high the word on irWord is captured at the clock edge; dOneHot[n] is high exactly when captured bits 14..12 equal n, and exactly one bit of dOneHot is high.
- R7: indirect equals captured bit 15 and qualBits equals captured bits 11..0; a word is held until the next load.
- R8: regRefExec is high exactly when dOneHot[7] is high, indirect is 0 and tOneHot[3] is high; ioExec is high exactly when dOneHot[7], indirect and tOneHot[3] are all high; the two are never high together.
- R9: In the cycle after regRefExec or ioExec is high, the step counter is 0 (tOneHot[0] high), even when run is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Run flag; low halts the step counter |
| scClear | input | 1 | Request to return the step counter to 0 |
| irLoad | input | 1 | Capture irWord at the next edge |
| irWord | input | 16 | Instruction word to capture |
| tOneHot | output | 16 | One-hot step timing lines |
| dOneHot | output | 8 | One-hot opcode decode lines |
| indirect | output | 1 | Captured bit 15 |
| qualBits | output | 12 | Captured bits 11..0 |
| regRefExec | output | 1 | Register-class instruction in step 3 |
| ioExec | output | 1 | Input/output instruction in step 3 |

## Verification
A wrong step count shows on tOneHot in the very cycle it arises, since the timing lines are a plain decode of the counter, and a missed automatic return to step 0 shows one cycle after a class flag. A wrong captured word shows on dOneHot, indirect and qualBits one edge after the load. The bench sweeps every value of the top four instruction bits against several qualifier patterns, runs each through a full pass of steps, and also halts, clears and wraps the counter, comparing every output in every cycle against an arithmetic model.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // return step counter to zero
    logic advance;  // step counter + 1
    logic capture;  // take a new instruction word
  } tdgStrobe_t;
endpackage

// File: rtl/tdg_ctrl.sv
module tdg_ctrl (
  input  logic               run,
  input  logic               scClear,
  input  logic               irLoad,
  input  logic               regRefExec,
  input  logic               ioExec,
  output tdg_pkg::tdgStrobe_t strobe
);
  logic classDone;

  always_comb begin
    classDone      = regRefExec | ioExec;
    strobe.clear   = scClear | classDone;
    strobe.advance = run & ~strobe.clear;
    strobe.capture = irLoad;
  end
endmodule

// File: rtl/tdg_datapath.sv
module tdg_datapath #(
  parameter int SC_W   = 4,
  parameter int WORD_W = 16,
  parameter int OP_W   = 3,
  localparam int T_N   = 1 << SC_W,
  localparam int D_N   = 1 << OP_W,
  localparam int Q_W   = WORD_W - 1 - OP_W
) (
  input  logic                clk,
  input  logic                rst,
  input  tdg_pkg::tdgStrobe_t strobe,
  input  logic [WORD_W-1:0]   irWord,
  output logic [T_N-1:0]      tOneHot,
  output logic [D_N-1:0]      dOneHot,
  output logic                indirect,
  output logic [Q_W-1:0]      qualBits,
  output logic                regRefExec,
  output logic                ioExec
);
  logic [SC_W-1:0]   seqCnt;
  logic [WORD_W-1:0] instr;
  logic [OP_W-1:0]   opField;

  always_ff @(posedge clk) begin
    if (rst) begin
      seqCnt <= '0;
    end else if (strobe.clear) begin
      seqCnt <= '0;
    end else if (strobe.advance) begin
      seqCnt <= seqCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      instr <= '0;
    end else if (strobe.capture) begin
      instr <= irWord;
    end
  end

  assign opField  = instr[WORD_W-2 -: OP_W];
  assign indirect = instr[WORD_W-1];
  assign qualBits = instr[Q_W-1:0];

  for (genvar k = 0; k < T_N; k++) begin : g_tDec
    assign tOneHot[k] = (seqCnt == SC_W'(k));
  end

  for (genvar n = 0; n < D_N; n++) begin : g_dDec
    assign dOneHot[n] = (opField == OP_W'(n));
  end

  assign regRefExec = dOneHot[D_N-1] & ~indirect & tOneHot[3];
  assign ioExec     = dOneHot[D_N-1] &  indirect & tOneHot[3];

  // R5
  t_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(tOneHot) == 1);

  // R6
  d_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(dOneHot) == 1);

  // R8
  class_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(regRefExec && ioExec));
endmodule

// File: rtl/tdg_top.sv
module tdg_top #(
  parameter int SC_W   = 4,
  parameter int WORD_W = 16,
  parameter int OP_W   = 3,
  localparam int T_N   = 1 << SC_W,
  localparam int D_N   = 1 << OP_W,
  localparam int Q_W   = WORD_W - 1 - OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              scClear,
  input  logic              irLoad,
  input  logic [WORD_W-1:0] irWord,
  output logic [T_N-1:0]    tOneHot,
  output logic [D_N-1:0]    dOneHot,
  output logic              indirect,
  output logic [Q_W-1:0]    qualBits,
  output logic              regRefExec,
  output logic              ioExec
);
  tdg_pkg::tdgStrobe_t strobe;

  tdg_ctrl u_ctrl (
    .run        (run),
    .scClear    (scClear),
    .irLoad     (irLoad),
    .regRefExec (regRefExec),
    .ioExec     (ioExec),
    .strobe     (strobe)
  );

  tdg_datapath #(
    .SC_W   (SC_W),
    .WORD_W (WORD_W),
    .OP_W   (OP_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .irWord     (irWord),
    .tOneHot    (tOneHot),
    .dOneHot    (dOneHot),
    .indirect   (indirect),
    .qualBits   (qualBits),
    .regRefExec (regRefExec),
    .ioExec     (ioExec)
  );

  // R2
  step_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !scClear && !regRefExec && !ioExec)
      |=> $past(tOneHot) == {tOneHot[0], tOneHot[T_N-1:1]});

  // R3
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !scClear && !regRefExec && !ioExec) |=> $stable(tOneHot));

  // R4
  ext_clear_chk: assert property (@(posedge clk) disable iff (rst)
    scClear |=> tOneHot[0]);

  // R9
  auto_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (regRefExec || ioExec) |=> tOneHot[0]);

  // R7
  ind_capture_chk: assert property (@(posedge clk) disable iff (rst)
    irLoad |=> indirect == $past(irWord[WORD_W-1]));
endmodule

// File: tb/tdg_top_test.sv
module tdg_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, run, scClear, irLoad;
  logic [15:0] irWord;
  logic [15:0] tOneHot;
  logic [7:0]  dOneHot;
  logic        indirect;
  logic [11:0] qualBits;
  logic        regRefExec, ioExec;

  int errors = 0;
  int checks = 0;

  // bench model
  int          mCnt;
  logic [15:0] mIr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdg_top uut (
    .clk(clk), .rst(rst), .run(run), .scClear(scClear), .irLoad(irLoad),
    .irWord(irWord), .tOneHot(tOneHot), .dOneHot(dOneHot),
    .indirect(indirect), .qualBits(qualBits),
    .regRefExec(regRefExec), .ioExec(ioExec)
  );

  task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expRr();
    return (mIr[14:12] == 3'd7) && !mIr[15] && (mCnt == 3);
  endfunction

  function automatic logic expIo();
    return (mIr[14:12] == 3'd7) && mIr[15] && (mCnt == 3);
  endfunction

  // compare every output with the model at the current (negedge) time
  task automatic checkAll(input string tTag);
    compare(tTag, 32'(tOneHot), 32'(16'b1 << mCnt));
    compare("R6 decode", 32'(dOneHot), 32'(8'b1 << mIr[14:12]));
    compare("R7 fields", {19'd0, indirect, qualBits}, {19'd0, mIr[15], mIr[11:0]});
    compare("R8 class", {30'd0, regRefExec, ioExec}, {30'd0, expRr(), expIo()});
  endtask

  // check now, drive inputs, let one edge pass, advance model
  task automatic tick(input string tTag, input logic r, input logic rn,
                      input logic clr, input logic ld, input logic [15:0] w);
    logic autoClr;
    checkAll(tTag);
    autoClr = expRr() | expIo();
    rst = r; run = rn; scClear = clr; irLoad = ld; irWord = w;
    @(negedge clk);
    if (r) begin
      mCnt = 0; mIr = '0;
    end else begin
      if (clr || autoClr) mCnt = 0;
      else if (rn) mCnt = (mCnt + 1) % 16;
      if (ld) mIr = w;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [11:0] qs [4];
    rst = 1; run = 1; scClear = 0; irLoad = 0; irWord = '0;
    mCnt = 0; mIr = '0;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    checkAll("R1 reset timing");
    tick("R1 reset timing", 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);

    // R2: wrap 15 -> 0 with a non-class opcode
    tick("R2 advance", 1'b0, 1'b0, 1'b1, 1'b1, 16'h3123);
    for (int i = 0; i < 18; i++) tick("R2 advance", 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);

    // R3: halt holds step value
    for (int i = 0; i < 6; i++) tick("R3 hold", 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);

    // R4: external clear, with run low and with run high
    tick("R4 clear", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
    for (int i = 0; i < 5; i++) tick("R4 clear", 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    tick("R4 clear", 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
    tick("R4 clear", 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);

    // R6 R7 R8 R9: sweep top nibble and qualifier patterns
    for (int hi = 0; hi < 16; hi++) begin
      qs[0] = 12'h000; qs[1] = 12'hFFF; qs[2] = 12'hA5A;
      qs[3] = {hi[3:0], hi[3:0], hi[3:0]};
      for (int q = 0; q < 4; q++) begin
        tick("R5 timing", 1'b0, 1'b0, 1'b1, 1'b1, {hi[3:0], qs[q]});
        for (int s = 0; s < 20; s++) tick("R5 timing", 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
      end
    end

    // R9: class flag in step 3 forces step 0 even while halted
    tick("R9 auto clear", 1'b0, 1'b0, 1'b1, 1'b1, 16'hF800);
    for (int i = 0; i < 3; i++) tick("R9 auto clear", 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    tick("R9 auto clear", 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    tick("R9 auto clear", 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    compare("R9 step zero", 32'(tOneHot), 32'h1);

    // R1: reset mid-run
    tick("R1 reset timing", 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    checkAll("R1 reset timing");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule